// File: doc/BRIEF.md
# Nibble Clock-Decoupling Transmit FIFO

This block takes 4-bit transmit data clocked in on a nibble write clock and moves it into the transmit bit-clock domain through an 8-entry decoupling buffer. On the read side, a serializer sends each nibble out one bit per bit clock, most significant bit first. The bit clock runs at four times the nibble rate. Both pointers cross between the domains in Gray code. After a re-centre the buffer holds four entries, so slow phase wander between the two clocks passes without loss.

When the buffer runs dry or fills up, the block raises a sticky error flag that can drive an interrupt. On underflow the last nibble is sent again. On overflow the incoming nibble is dropped. A FIFO reset pulse clears the flag and moves the pointers back to half depth. This pulse must be applied after the transmitter powers up.

The read clock is either the reference clock or, for loop timing, the recovered receive clock. A bypass input sends a serial bit stream straight to the output and leaves the buffer out of the path.

Top module: `nib_tx_fifo`

## Requirements
- R1: The nibbles written on `wr_clk_i` leave `ser_o` in the same order, most significant bit first, one bit per read-clock cycle, with no nibble lost, repeated or reordered.
- R2: If the write-clock edges wander by up to ±10 ns around their mean position, the data is still reproduced without error and `err_o` stays 0.
- R3: If writes arrive faster than reads until the buffer is full, `err_o` becomes 1.
- R4: If writes stop until the buffer is empty, `err_o` becomes 1, and `ser_o` keeps repeating the last nibble read, so that the bit stream has a period of 4 bits.
- R5: Once `err_o` is 1, it stays 1 until a FIFO reset, even after the clock rates are back to normal.
- R6: While `frst_i` is high, and for a few clocks after it falls, `err_o` is cleared and both pointers are re-centred to four entries apart. The data written after that is reproduced without error. The pulse must last at least 3 write-clock periods.
- R7: With `loop_i`=1, the read side and the serializer run on `rec_clk_i` instead of `ref_clk_i`, and the data is reproduced without error after a FIFO reset.
- R8: With `bypass_i`=1, `ser_o` equals the `byp_dat_i` value sampled at the previous read-clock rising edge.
- R9: While `rst_ni` is low, `ser_o` is 0 and `err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk_i | input | 1 | Reference-derived bit clock |
| rec_clk_i | input | 1 | Recovered receive bit clock, used for loop timing |
| wr_clk_i | input | 1 | Nibble write clock, one quarter of the bit rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| loop_i | input | 1 | 1 selects rec_clk_i as the read clock |
| bypass_i | input | 1 | 1 routes byp_dat_i to ser_o around the buffer |
| byp_dat_i | input | 1 | Serial data for the bypass path |
| frst_i | input | 1 | FIFO reset pulse: clears the error flag and re-centres the pointers |
| dat_i | input | 4 | Nibble written on each wr_clk_i rising edge |
| ser_o | output | 1 | Serial transmit data |
| err_o | output | 1 | Sticky overflow/underflow flag |

## Verification
The assertions take several things for granted about the inputs. Each FIFO reset pulse is long enough for both synchronizers to see it. `loop_i` and `bypass_i` are static between resets, so a change is never judged in the middle of a clock switch. `byp_dat_i` changes only away from the read-clock edge. The bench follows the same rules: its pulse is 200 ns long, it issues a FIFO reset after every mode change, it drives the bypass bits on falling edges, and it keeps the write wander within ±10 ns except in the deliberate overflow and underflow phases.

// File: rtl/ntf_pkg.sv
package ntf_pkg;
  localparam int unsigned NIB_W      = 4;
  localparam int unsigned FIFO_DEPTH = 8;
endpackage

// File: rtl/ntf_sync.sv
module ntf_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/ntf_wr_side.sv
module ntf_wr_side #(
  parameter int unsigned DW    = 4,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frst_i,
  input  logic [AW:0]   rgray_s_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0]   wgray_o,
  output logic          full_o,
  output logic          ovf_o
);
  localparam logic [AW:0] MID  = (AW+1)'(DEPTH/2);
  localparam logic [AW:0] MIDG = MID ^ (MID >> 1);

  logic [AW:0] wbin_q, wgray_q, wbin_n;
  logic        ovf_q;

  assign wbin_n = wbin_q + 1'b1;
  assign full_o = (wgray_q == {~rgray_s_i[AW:AW-1], rgray_s_i[AW-2:0]});
  assign we_o   = !frst_i && !full_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= MID;
      wgray_q <= MIDG;
      ovf_q   <= 1'b0;
    end else if (frst_i) begin
      wbin_q  <= MID;
      wgray_q <= MIDG;
      ovf_q   <= 1'b0;
    end else if (full_o) begin
      ovf_q   <= 1'b1;  // incoming nibble dropped
    end else begin
      wbin_q  <= wbin_n;
      wgray_q <= wbin_n ^ (wbin_n >> 1);
    end
  end

  assign waddr_o = wbin_q[AW-1:0];
  assign wgray_o = wgray_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/ntf_rd_side.sv
module ntf_rd_side #(
  parameter int unsigned DW    = 4,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter int unsigned CW    = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frst_i,
  input  logic [AW:0]   wgray_s_i,
  input  logic          ovf_s_i,
  input  logic [DW-1:0] rdata_i,
  input  logic          bypass_i,
  input  logic          byp_dat_i,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rgray_o,
  output logic          empty_o,
  output logic          ser_o,
  output logic          err_o
);
  logic [CW-1:0] bcnt_q;
  logic [DW-1:0] sreg_q, last_q;
  logic [AW:0]   rbin_q, rgray_q, rbin_n;
  logic          err_q, byp_q, ld;

  assign ld      = (bcnt_q == CW'(DW-1));
  assign empty_o = (rgray_q == wgray_s_i);
  assign rbin_n  = rbin_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bcnt_q  <= '0;
      sreg_q  <= '0;
      last_q  <= '0;
      rbin_q  <= '0;
      rgray_q <= '0;
      err_q   <= 1'b0;
      byp_q   <= 1'b0;
    end else begin
      bcnt_q <= bcnt_q + 1'b1;
      byp_q  <= byp_dat_i;
      if (ld) begin
        if (frst_i || empty_o) begin
          sreg_q <= last_q;  // underflow or hold: repeat last nibble
        end else begin
          sreg_q <= rdata_i;
          last_q <= rdata_i;
        end
      end else begin
        sreg_q <= sreg_q << 1;
      end
      if (frst_i) begin
        rbin_q  <= '0;
        rgray_q <= '0;
        err_q   <= 1'b0;
      end else begin
        if (ld && !empty_o) begin
          rbin_q  <= rbin_n;
          rgray_q <= rbin_n ^ (rbin_n >> 1);
        end
        if ((ld && empty_o) || ovf_s_i) err_q <= 1'b1;
      end
    end
  end

  assign raddr_o = rbin_q[AW-1:0];
  assign rgray_o = rgray_q;
  assign ser_o   = bypass_i ? byp_q : sreg_q[DW-1];
  assign err_o   = err_q;
endmodule

// File: rtl/nib_tx_fifo.sv
module nib_tx_fifo #(
  parameter int unsigned DW    = ntf_pkg::NIB_W,
  parameter int unsigned DEPTH = ntf_pkg::FIFO_DEPTH
) (
  input  logic          ref_clk_i,
  input  logic          rec_clk_i,
  input  logic          wr_clk_i,
  input  logic          rst_ni,
  input  logic          loop_i,
  input  logic          bypass_i,
  input  logic          byp_dat_i,
  input  logic          frst_i,
  input  logic [DW-1:0] dat_i,
  output logic          ser_o,
  output logic          err_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic          rd_clk;
  logic          frst_w, frst_r, we, full, empty, ovf_w, ovf_r;
  logic [AW-1:0] waddr, raddr;
  logic [AW:0]   wgray, rgray, wgray_r, rgray_w;
  logic [DW-1:0] mem [DEPTH];

  // loop_i static between FIFO resets
  assign rd_clk = loop_i ? rec_clk_i : ref_clk_i;

  ntf_sync #(.W(1)) u_frst_w (.clk_i(wr_clk_i), .rst_ni(rst_ni), .d_i(frst_i), .q_o(frst_w));
  ntf_sync #(.W(1)) u_frst_r (.clk_i(rd_clk), .rst_ni(rst_ni), .d_i(frst_i), .q_o(frst_r));
  ntf_sync #(.W(1)) u_ovf_r (.clk_i(rd_clk), .rst_ni(rst_ni), .d_i(ovf_w), .q_o(ovf_r));
  ntf_sync #(.W(AW+1)) u_wg_r (.clk_i(rd_clk), .rst_ni(rst_ni), .d_i(wgray), .q_o(wgray_r));
  ntf_sync #(.W(AW+1)) u_rg_w (.clk_i(wr_clk_i), .rst_ni(rst_ni), .d_i(rgray), .q_o(rgray_w));

  ntf_wr_side #(.DW(DW), .DEPTH(DEPTH)) u_wr (
    .clk_i(wr_clk_i), .rst_ni(rst_ni), .frst_i(frst_w), .rgray_s_i(rgray_w),
    .we_o(we), .waddr_o(waddr), .wgray_o(wgray), .full_o(full), .ovf_o(ovf_w)
  );

  always_ff @(posedge wr_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= dat_i;
    end
  end

  ntf_rd_side #(.DW(DW), .DEPTH(DEPTH)) u_rd (
    .clk_i(rd_clk), .rst_ni(rst_ni), .frst_i(frst_r), .wgray_s_i(wgray_r),
    .ovf_s_i(ovf_r), .rdata_i(mem[raddr]), .bypass_i(bypass_i), .byp_dat_i(byp_dat_i),
    .raddr_o(raddr), .rgray_o(rgray), .empty_o(empty), .ser_o(ser_o), .err_o(err_o)
  );
endmodule

// File: rtl/ntf_chk.sv
module ntf_chk #(
  parameter int unsigned AW = 3
) (
  input logic        rd_clk_i,
  input logic        wr_clk_i,
  input logic        rst_ni,
  input logic        frst_r_i,
  input logic        frst_w_i,
  input logic        err_i,
  input logic        ser_i,
  input logic        bypass_i,
  input logic        byp_dat_i,
  input logic        full_i,
  input logic [AW:0] wgray_i,
  input logic [AW:0] rgray_i
);
  logic armed_r_q, armed_w_q;

  always_ff @(posedge rd_clk_i or negedge rst_ni)
    if (!rst_ni) armed_r_q <= 1'b0; else armed_r_q <= 1'b1;
  always_ff @(posedge wr_clk_i or negedge rst_ni)
    if (!rst_ni) armed_w_q <= 1'b0; else armed_w_q <= 1'b1;

  // R5
  err_sticky_chk: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    err_i && !frst_r_i |=> err_i);
  // R6
  err_clear_chk: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    frst_r_i |=> !err_i);
  // R8
  bypass_path_chk: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    armed_r_q && bypass_i && $past(bypass_i) |-> ser_i == $past(byp_dat_i));
  // R1
  wr_gray_chk: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    armed_w_q && !$past(frst_w_i) |-> $onehot0(wgray_i ^ $past(wgray_i)));
  // R1
  rd_gray_chk: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    armed_r_q && !$past(frst_r_i) |-> $onehot0(rgray_i ^ $past(rgray_i)));
  // R3
  full_drop_chk: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    armed_w_q && full_i && !frst_w_i |=> $stable(wgray_i));
endmodule

bind nib_tx_fifo ntf_chk #(.AW(AW)) u_chk (
  .rd_clk_i(rd_clk), .wr_clk_i(wr_clk_i), .rst_ni(rst_ni), .frst_r_i(frst_r),
  .frst_w_i(frst_w), .err_i(err_o), .ser_i(ser_o), .bypass_i(bypass_i),
  .byp_dat_i(byp_dat_i), .full_i(full), .wgray_i(wgray), .rgray_i(rgray)
);

// File: tb/sim_nib_tx_fifo.sv
`timescale 1ns/1ps
module sim_nib_tx_fifo;
  logic       ref_clk = 0, rec_clk = 0, wr_clk = 0, rst_ni = 0;
  logic       loop_i = 0, bypass_i = 0, byp_dat_i = 0, frst_i = 0;
  logic [3:0] dat_i = 0;
  logic       ser_o, err_o;

  int  checks = 0, errors = 0;
  bit  wr_run = 1, wander = 0;
  int  wr_per = 40, wcyc = 0;
  bit  bits [512];

  nib_tx_fifo u0 (
    .ref_clk_i(ref_clk), .rec_clk_i(rec_clk), .wr_clk_i(wr_clk), .rst_ni(rst_ni),
    .loop_i(loop_i), .bypass_i(bypass_i), .byp_dat_i(byp_dat_i), .frst_i(frst_i),
    .dat_i(dat_i), .ser_o(ser_o), .err_o(err_o)
  );

  initial forever #5 ref_clk = ~ref_clk;
  initial begin #3; forever #5 rec_clk = ~rec_clk; end

  initial forever begin
    if (wr_run) begin
      int per;
      per = wander ? ((wcyc % 10 < 5) ? 42 : 38) : wr_per;
      wr_clk = 1; #(per / 2);
      wr_clk = 0; dat_i = dat_i + 1'b1; wcyc++;
      #(per - per / 2);
    end else #5;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fifo_reset();
    frst_i = 1; #200; frst_i = 0; #400;
  endtask

  task automatic capture(int n, bit use_rec);
    for (int i = 0; i < n; i++) begin
      if (use_rec) @(negedge rec_clk); else @(negedge ref_clk);
      bits[i] = ser_o;
    end
  endtask

  function automatic bit in_order(int n);
    for (int off = 0; off < 4; off++) begin
      bit ok = 1;
      int nj = (n - off) / 4;
      for (int j = 0; j < nj - 1; j++) begin
        logic [3:0] a, b;
        a = {bits[off+4*j], bits[off+4*j+1], bits[off+4*j+2], bits[off+4*j+3]};
        b = {bits[off+4*j+4], bits[off+4*j+5], bits[off+4*j+6], bits[off+4*j+7]};
        if (b != a + 4'd1) ok = 0;
      end
      if (ok) return 1;
    end
    return 0;
  endfunction

  function automatic bit periodic4(int n);
    for (int i = 0; i < n - 4; i++) if (bits[i] != bits[i+4]) return 0;
    return 1;
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    #50;
    chk(ser_o == 0, "R9 ser_o in reset", ser_o, 0);
    chk(err_o == 0, "R9 err_o in reset", err_o, 0);
    #17 rst_ni = 1;
    #200;

    fifo_reset();
    capture(400, 0);
    chk(in_order(400), "R1 nibble order", 0, 1);
    chk(err_o == 0, "R1 no error", err_o, 0);

    wander = 1;
    fifo_reset();
    capture(400, 0);
    chk(in_order(400), "R2 order under wander", 0, 1);
    chk(err_o == 0, "R2 no error under wander", err_o, 0);
    wander = 0;

    wr_per = 20; #1500;
    chk(err_o == 1, "R3 overflow flag", err_o, 1);
    wr_per = 40; #1000;
    chk(err_o == 1, "R5 sticky after overflow", err_o, 1);
    frst_i = 1; #200; frst_i = 0; #60;
    chk(err_o == 0, "R6 flag cleared", err_o, 0);
    #400;
    capture(400, 0);
    chk(in_order(400), "R6 order after recentre", 0, 1);
    chk(err_o == 0, "R6 no error after recentre", err_o, 0);

    wr_run = 0; #400;
    chk(err_o == 1, "R4 underflow flag", err_o, 1);
    capture(200, 0);
    chk(periodic4(200), "R4 last nibble repeated", 0, 1);
    wr_run = 1; #600;
    chk(err_o == 1, "R5 sticky after underflow", err_o, 1);

    loop_i = 1;
    fifo_reset();
    capture(400, 1);
    chk(in_order(400), "R7 order in loop timing", 0, 1);
    chk(err_o == 0, "R7 no error in loop timing", err_o, 0);

    loop_i = 0;
    fifo_reset();
    bypass_i = 1;
    @(negedge ref_clk);
    for (int i = 0; i < 40; i++) begin
      bit b;
      b = 1'($urandom(32'd7 + i));
      byp_dat_i = b;
      @(negedge ref_clk);
      chk(ser_o == b, "R8 bypass bit", ser_o, b);
    end

    summary();
    $finish;
  end
endmodule